// File: doc/BRIEF.md
# Touch Panel Measurement Sequencer

This block runs the measurement side of a resistive touch panel. It keeps a short programmable list of switch-control words. Each word names which panel line goes to the converter input, which lines act as the positive and negative references, and which lines are grounded or powered. When enabled, the block walks the list in order. For each entry it sets the analog switch controls, waits a programmed settle time and requests one or more conversions. It keeps the last 12-bit result of each entry. At the end of the list it raises a completion flag.

Software builds the list through a single command port. A read of that port rewinds the list. Each nonzero write adds one entry, and a zero write closes the list. Results are read back through a data port. Each read returns the next 32-bit word, and each word holds the results of two consecutive entries. The analog switches and the converter are outside the block. The block talks to them through `sw_ctrl` and a start/done handshake.

Top module: `touch_cmd_seq`

The register port is selected by `reg_addr` with these values:
- 0: control. Bit 0 enables the engine and bit 1 selects command-list operation.
- 1: status. Bit 2 is the done flag, and writing 1 to bit 2 clears it.
- 2: settle tick count.
- 3: repeat count.
- 4: command port.
- 5: result pop port.

Read data appears on `reg_rdata` one clock after `reg_rd`.

## Requirements
- R1: After reset, `sw_ctrl`, `adc_start` and `tdata_flag` are 0, and the control, status and result-pop reads return 0.
- R2: A read of the command port (address 4) rewinds the list. Each following nonzero write appends one entry. A zero write closes the list with the entries appended so far. Writes after the close are ignored until the next rewind read. Appends beyond DEPTH entries are dropped. An empty closed list starts no measurement.
- R3: A measurement starts only while control bit 0 and bit 1 are both 1, the closed list is nonempty and the done flag is clear.
- R4: For entry k, taken in list order, `sw_ctrl` equals bits 25..7 of the k-th command word. It holds that value through every conversion of that entry.
- R5: The first `adc_start` of an entry comes exactly SETTLE*TICK_DIV+2 clocks after `sw_ctrl` takes the entry's value. `adc_start` is always a single-cycle pulse.
- R6: Each entry is converted max(REPEAT,1) times. The value stored for the entry is the `adc_data` that came with its last `adc_done`.
- R7: After the last entry, status bit 2 (`tdata_flag`) is set and `sw_ctrl` returns to 0. The flag stays set until software writes 1 to status bit 2. While it is set, no new measurement starts.
- R8: Each read of address 5 returns the next packed word. Entry 2i sits in bits 11..0 and entry 2i+1 sits in bits 27..16, and all other bits are 0. For an odd list, the last word's high half is 0. Reads past ceil(len/2) words return 0. The pop position rewinds when a measurement starts.
- R9: Clearing either control bit during a measurement aborts it. `sw_ctrl` returns to 0, no further `adc_start` is issued and the done flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| sw_ctrl | output | 19 | Switch control (command bits 25..7) |
| adc_start | output | 1 | Conversion request pulse |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | 12 | Conversion result |
| tdata_flag | output | 1 | Measurement-set complete flag |

## Verification
The bench first targets list loading at its edges: an empty list, a list that overruns the depth, and writes sent after the terminating zero. A design that mishandles these would sequence the wrong number of entries or keep stale words. It then targets odd list lengths and pops past the end. A wrong packer would leak stale data into the unused high half or keep returning old words. It measures the exact settle gap for zero and nonzero tick counts, so an off-by-one in the prescaler or the compare shows up as a shifted start. Finally it checks gating, the held done flag and a mid-settle abort. A design that got these wrong would start conversions while disabled, re-run without an acknowledge, or leave the switches driven after the abort.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int CMD_LSB  = 7;
  localparam int CMD_MSB  = 25;
  localparam int CMD_W    = CMD_MSB - CMD_LSB + 1;
  localparam int DONE_BIT = 2;
  localparam int SLOT_W   = 16;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_SETTLE = 3'd2;
  localparam logic [2:0] A_REPEAT = 3'd3;
  localparam logic [2:0] A_CMD    = 3'd4;
  localparam logic [2:0] A_TDATA  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETTLE, S_START, S_WAIT, S_STORE, S_FIN
  } seq_state_t;
endpackage

// File: rtl/tcs_cmd_list.sv
module tcs_cmd_list
  import tcs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rewind,
  input  logic              wr_en,
  input  logic [31:0]       wr_word,
  input  logic [IW-1:0]     rd_idx,
  output logic [CMD_W-1:0]  rd_cmd,
  output logic [CW-1:0]     len
);
  logic [CMD_W-1:0] mem [DEPTH];
  logic [CW-1:0]    wptr;
  logic             closed;
  logic             append;
  logic             terminate;

  assign append    = wr_en && !closed && (wr_word != 32'd0) && (wptr < CW'(DEPTH));
  assign terminate = wr_en && !closed && (wr_word == 32'd0);

  // storage without reset so it can map to distributed or block RAM
  always_ff @(posedge clk) begin
    if (append) mem[wptr[IW-1:0]] <= wr_word[CMD_MSB:CMD_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      closed <= 1'b0;
      len    <= '0;
    end else if (rewind) begin
      wptr   <= '0;
      closed <= 1'b0;
      len    <= '0;
    end else begin
      if (append) wptr <= wptr + 1'b1;
      if (terminate) begin
        closed <= 1'b1;
        len    <= wptr;
      end
    end
  end

  assign rd_cmd = mem[rd_idx];
endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int DIV   = 2000,
  parameter int CNT_W = $clog2(DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = wrap && !restart;
endmodule

// File: rtl/tcs_result_buf.sv
module tcs_result_buf
  import tcs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SMP_W  = 12,
  parameter int IW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [SMP_W-1:0]  wr_val,
  input  logic              restart,
  input  logic              pop,
  input  logic [CW-1:0]     len,
  output logic [31:0]       rd_word
);
  localparam int WORDS = (DEPTH + 1) / 2;
  localparam int PW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [SMP_W-1:0] lo_mem [WORDS];
  logic [SMP_W-1:0] hi_mem [WORDS];
  logic [CW-1:0]    rptr;
  logic [CW:0]      nwords_w;
  logic [CW-1:0]    nwords;
  logic [PW-1:0]    waddr;
  logic [PW-1:0]    raddr;
  logic             have;

  assign nwords_w = ({1'b0, len} + 1'b1) >> 1;
  assign nwords   = nwords_w[CW-1:0];
  assign waddr    = PW'(wr_idx >> 1);
  assign raddr    = PW'(rptr);
  assign have     = (rptr < nwords);

  // even entry fills the low slot and clears the partner slot
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (!wr_idx[0]) begin
        lo_mem[waddr] <= wr_val;
        hi_mem[waddr] <= '0;
      end else begin
        hi_mem[waddr] <= wr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) rptr <= '0;
    else if (pop && have) rptr <= rptr + 1'b1;
  end

  always_comb begin
    rd_word = '0;
    if (have) begin
      rd_word[SLOT_W-1:0]        = SLOT_W'(lo_mem[raddr]);
      rd_word[2*SLOT_W-1:SLOT_W] = SLOT_W'(hi_mem[raddr]);
    end
  end
endmodule

// File: rtl/tcs_sequencer.sv
module tcs_sequencer
  import tcs_pkg::*;
#(
  parameter int IW       = 3,
  parameter int CW       = 4,
  parameter int SETTLE_W = 16,
  parameter int REP_W    = 8,
  parameter int SMP_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gate,
  input  logic                flag,
  input  logic [CW-1:0]       len,
  input  logic [CMD_W-1:0]    cmd_in,
  input  logic [SETTLE_W-1:0] settle_ticks,
  input  logic [REP_W-1:0]    rep_cnt,
  input  logic                tick,
  input  logic                adc_done,
  input  logic [SMP_W-1:0]    adc_data,
  output logic [IW-1:0]       rd_idx,
  output logic [CMD_W-1:0]    sw_ctrl,
  output logic                adc_start,
  output logic                presc_restart,
  output logic                meas_begin,
  output logic                wr_en,
  output logic [IW-1:0]       wr_idx,
  output logic [SMP_W-1:0]    wr_val,
  output logic                set_flag
);
  seq_state_t          state;
  logic [CW-1:0]       idx;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [REP_W:0]      conv_cnt;
  logic [REP_W:0]      eff_rep;
  logic                last_conv;

  assign eff_rep       = (rep_cnt == '0) ? (REP_W+1)'(1) : {1'b0, rep_cnt};
  assign last_conv     = (conv_cnt + 1'b1) >= eff_rep;
  assign rd_idx        = idx[IW-1:0];
  assign presc_restart = (state == S_LOAD);
  assign set_flag      = (state == S_FIN) && gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      settle_cnt <= '0;
      conv_cnt   <= '0;
      sw_ctrl    <= '0;
      adc_start  <= 1'b0;
      meas_begin <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_val     <= '0;
    end else begin
      adc_start  <= 1'b0;
      meas_begin <= 1'b0;
      wr_en      <= 1'b0;
      if (state != S_IDLE && !gate) begin
        state   <= S_IDLE;
        sw_ctrl <= '0;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (gate && !flag && len != '0) begin
              idx        <= '0;
              meas_begin <= 1'b1;
              state      <= S_LOAD;
            end
          end
          S_LOAD: begin
            sw_ctrl    <= cmd_in;
            settle_cnt <= '0;
            conv_cnt   <= '0;
            state      <= S_SETTLE;
          end
          S_SETTLE: begin
            if (settle_cnt == settle_ticks) state <= S_START;
            else if (tick) settle_cnt <= settle_cnt + 1'b1;
          end
          S_START: begin
            adc_start <= 1'b1;
            state     <= S_WAIT;
          end
          S_WAIT: begin
            if (adc_done) begin
              if (last_conv) begin
                wr_en  <= 1'b1;
                wr_idx <= idx[IW-1:0];
                wr_val <= adc_data;
                state  <= S_STORE;
              end else begin
                conv_cnt <= conv_cnt + 1'b1;
                state    <= S_START;
              end
            end
          end
          S_STORE: begin
            if ((idx + 1'b1) == len) begin
              state <= S_FIN;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_LOAD;
            end
          end
          S_FIN: begin
            sw_ctrl <= '0;
            state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/touch_cmd_seq.sv
module touch_cmd_seq
  import tcs_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SMP_W    = 12,
  parameter int TICK_DIV = 2000,
  parameter int SETTLE_W = 16,
  parameter int REP_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [CMD_W-1:0]   sw_ctrl,
  output logic               adc_start,
  input  logic               adc_done,
  input  logic [SMP_W-1:0]   adc_data,
  output logic               tdata_flag
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]          ctrl_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [REP_W-1:0]    rep_q;
  logic                seq_gate;
  logic                flag_clr;
  logic                list_rewind;
  logic                list_wr;
  logic                pop;
  logic [CW-1:0]       list_len;
  logic [IW-1:0]       rd_idx;
  logic [CMD_W-1:0]    cur_cmd;
  logic                tick;
  logic                presc_restart;
  logic                meas_begin;
  logic                res_wr;
  logic [IW-1:0]       res_idx;
  logic [SMP_W-1:0]    res_val;
  logic                set_flag;
  logic [31:0]         pop_word;

  assign seq_gate    = ctrl_q[0] & ctrl_q[1];
  assign flag_clr    = reg_wr && (reg_addr == A_STAT) && reg_wdata[DONE_BIT];
  assign list_rewind = reg_rd && (reg_addr == A_CMD);
  assign list_wr     = reg_wr && (reg_addr == A_CMD);
  assign pop         = reg_rd && (reg_addr == A_TDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      settle_q <= '0;
      rep_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:   ctrl_q   <= reg_wdata[1:0];
        A_SETTLE: settle_q <= reg_wdata[SETTLE_W-1:0];
        A_REPEAT: rep_q    <= reg_wdata[REP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           tdata_flag <= 1'b0;
    else if (set_flag) tdata_flag <= 1'b1;
    else if (flag_clr) tdata_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:   reg_rdata <= {30'd0, ctrl_q};
        A_STAT:   reg_rdata <= 32'(tdata_flag) << DONE_BIT;
        A_SETTLE: reg_rdata <= 32'(settle_q);
        A_REPEAT: reg_rdata <= 32'(rep_q);
        A_TDATA:  reg_rdata <= pop_word;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  tcs_cmd_list #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_list (
    .clk(clk), .rst(rst), .rewind(list_rewind), .wr_en(list_wr),
    .wr_word(reg_wdata), .rd_idx(rd_idx), .rd_cmd(cur_cmd), .len(list_len)
  );

  tcs_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .restart(presc_restart), .tick(tick)
  );

  tcs_sequencer #(.IW(IW), .CW(CW), .SETTLE_W(SETTLE_W), .REP_W(REP_W),
                  .SMP_W(SMP_W)) u_seq (
    .clk(clk), .rst(rst), .gate(seq_gate), .flag(tdata_flag),
    .len(list_len), .cmd_in(cur_cmd), .settle_ticks(settle_q),
    .rep_cnt(rep_q), .tick(tick), .adc_done(adc_done), .adc_data(adc_data),
    .rd_idx(rd_idx), .sw_ctrl(sw_ctrl), .adc_start(adc_start),
    .presc_restart(presc_restart), .meas_begin(meas_begin),
    .wr_en(res_wr), .wr_idx(res_idx), .wr_val(res_val), .set_flag(set_flag)
  );

  tcs_result_buf #(.DEPTH(DEPTH), .SMP_W(SMP_W), .IW(IW), .CW(CW)) u_res (
    .clk(clk), .rst(rst), .wr_en(res_wr), .wr_idx(res_idx), .wr_val(res_val),
    .restart(meas_begin), .pop(pop), .len(list_len), .rd_word(pop_word)
  );
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int W     = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          adc_start,
  input logic [W-1:0]  sw_ctrl,
  input logic          gate,
  input logic          flag,
  input logic          flag_clr,
  input logic [CW-1:0] list_len
);
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  assert_no_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !adc_start);

  assert_switch_held_R4: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $stable(sw_ctrl));

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (rst)
    list_len <= CW'(DEPTH));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  assert_switch_off_R9: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (sw_ctrl == '0));
endmodule

bind touch_cmd_seq tcs_checker #(.DEPTH(DEPTH), .CW(CW), .W(tcs_pkg::CMD_W)) u_chk (
  .clk(clk), .rst(rst), .adc_start(adc_start), .sw_ctrl(sw_ctrl),
  .gate(seq_gate), .flag(tdata_flag), .flag_clr(flag_clr), .list_len(list_len)
);

// File: tb/sim_touch_cmd_seq.sv
`timescale 1ns/1ps
module sim_touch_cmd_seq;
  localparam int DEPTH = 8;
  localparam int TDIV  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [18:0] sw_ctrl;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic        tdata_flag;

  always #2.5 clk = ~clk;

  touch_cmd_seq #(.DEPTH(DEPTH), .TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_ctrl(sw_ctrl),
    .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .tdata_flag(tdata_flag)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // converter model and monitor, all at the falling edge
  int          cyc = 0, chg_cyc = 0, nconv = 0, pend = 0;
  logic [18:0] sw_prev = '0;
  logic [18:0] conv_sw    [0:63];
  logic [11:0] conv_data  [0:63];
  int          conv_delay [0:63];

  always @(negedge clk) begin
    cyc++;
    adc_done = 1'b0;
    if (sw_ctrl !== sw_prev) begin
      chg_cyc = cyc;
      sw_prev = sw_ctrl;
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        adc_done = 1'b1;
        adc_data = 12'($urandom);
        if (nconv > 0 && nconv <= 64) conv_data[nconv-1] = adc_data;
      end
    end
    if (adc_start === 1'b1) begin
      if (nconv < 64) begin
        conv_sw[nconv]    = sw_ctrl;
        conv_delay[nconv] = cyc - chg_cyc;
      end
      nconv++;
      pend = 3;
    end
  end

  logic [31:0] cmds [0:15];

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s : got %h expected %h", what, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic make_cmds(input int n);
    for (int k = 0; k < n; k++)
      cmds[k] = ($urandom & 32'h03FF_F000) | (32'(k + 1) << 7) | ($urandom & 32'hFC00_007F);
  endtask

  // rewind, append n words, terminate, then n_after ignored writes
  task automatic load_list(input int n, input int n_after);
    logic [31:0] d;
    reg_read(3'd4, d);
    for (int k = 0; k < n; k++) reg_write(3'd4, cmds[k]);
    reg_write(3'd4, 32'd0);
    for (int k = 0; k < n_after; k++) reg_write(3'd4, 32'h0200_0000 | 32'($urandom & 32'hFFFF));
  endtask

  function automatic logic [31:0] pack_word(input int w, input int len, input int r);
    logic [31:0] v;
    v = '0;
    v[11:0] = conv_data[(2*w)*r + r - 1];
    if (2*w + 1 < len) v[27:16] = conv_data[(2*w + 1)*r + r - 1];
    return v;
  endfunction

  task automatic run_measure(input int settle, input int rep, input int len);
    logic [31:0] d;
    int r;
    r = (rep == 0) ? 1 : rep;
    reg_write(3'd1, 32'h4);
    reg_write(3'd2, 32'(settle));
    reg_write(3'd3, 32'(rep));
    nconv = 0;
    reg_write(3'd0, 32'd3);
    for (int i = 0; i < 20000 && tdata_flag !== 1'b1; i++) @(negedge clk);
    check("R7 done flag set", 32'(tdata_flag), 32'd1);
    check("R7 switches released", 32'(sw_ctrl), 32'd0);
    reg_write(3'd0, 32'd0);
    check("R6 conversion count", 32'(nconv), 32'(len * r));
    for (int j = 0; j < len; j++) begin
      for (int k = 0; k < r; k++)
        check($sformatf("R4 entry %0d switch word", j), 32'(conv_sw[j*r + k]), 32'(cmds[j][25:7]));
      check($sformatf("R5 entry %0d settle gap", j), 32'(conv_delay[j*r]), 32'(settle * TDIV + 2));
    end
    for (int w = 0; w < (len + 1) / 2; w++) begin
      reg_read(3'd5, d);
      check($sformatf("R8 packed word %0d", w), d, pack_word(w, len, r));
    end
    reg_read(3'd5, d);
    check("R8 pop past end", d, 32'd0);
    reg_read(3'd1, d);
    check("R7 status bit 2", d, 32'h4);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    logic [31:0] d;
    int save;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sw_ctrl after reset", 32'(sw_ctrl), 32'd0);
    check("R1 adc_start after reset", 32'(adc_start), 32'd0);
    check("R1 flag after reset", 32'(tdata_flag), 32'd0);
    reg_read(3'd0, d); check("R1 control reads 0", d, 32'd0);
    reg_read(3'd1, d); check("R1 status reads 0", d, 32'd0);
    reg_read(3'd5, d); check("R1 pop reads 0", d, 32'd0);

    // full six-entry list in pairs
    make_cmds(6); load_list(6, 0);
    run_measure(3, 2, 6);

    // flag still set: enabling again must not start (R7, R3)
    nconv = 0;
    reg_write(3'd0, 32'd3);
    repeat (60) @(negedge clk);
    check("R7 no restart while flag set", 32'(nconv), 32'd0);
    reg_write(3'd0, 32'd0);

    // gating: only one control bit set (R3)
    reg_write(3'd1, 32'h4);
    reg_write(3'd0, 32'd1);
    repeat (60) @(negedge clk);
    check("R3 engine bit alone", 32'(nconv), 32'd0);
    reg_write(3'd0, 32'd2);
    repeat (60) @(negedge clk);
    check("R3 select bit alone", 32'(nconv), 32'd0);
    check("R3 switches idle", 32'(sw_ctrl), 32'd0);
    reg_write(3'd0, 32'd0);

    // empty list (R2)
    load_list(0, 0);
    reg_write(3'd0, 32'd3);
    repeat (60) @(negedge clk);
    check("R2 empty list starts nothing", 32'(nconv), 32'd0);
    check("R2 empty list no flag", 32'(tdata_flag), 32'd0);
    reg_write(3'd0, 32'd0);

    // odd length, repeat 0 means one conversion, zero settle (R6, R8, R5)
    make_cmds(3); load_list(3, 0);
    run_measure(0, 0, 3);

    // overrun beyond depth (R2)
    make_cmds(10); load_list(10, 0);
    run_measure(1, 1, DEPTH);

    // writes after terminator ignored (R2)
    make_cmds(2); load_list(2, 3);
    run_measure(2, 3, 2);

    // abort during settle (R9)
    make_cmds(4); load_list(4, 0);
    reg_write(3'd1, 32'h4);
    reg_write(3'd2, 32'd5);
    reg_write(3'd3, 32'd1);
    nconv = 0;
    reg_write(3'd0, 32'd3);
    for (int i = 0; i < 200 && sw_ctrl == '0; i++) @(negedge clk);
    reg_write(3'd0, 32'd0);
    @(negedge clk);
    check("R9 switches released on abort", 32'(sw_ctrl), 32'd0);
    save = nconv;
    repeat (120) @(negedge clk);
    check("R9 no conversion after abort", 32'(nconv), 32'(save));
    check("R9 no flag after abort", 32'(tdata_flag), 32'd0);

    // random lists
    for (int it = 0; it < 5; it++) begin
      int n, s, rp;
      n  = 1 + int'($urandom % DEPTH);
      s  = int'($urandom % 6);
      rp = int'($urandom % 4);
      make_cmds(n); load_list(n, 0);
      run_measure(s, rp, n);
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog : got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule